// File: doc/BRIEF.md
# Cascadable Duty-Programmable Clock Divider

This block turns a fast oscillator clock into one or more slower clocks. Each stage divides its input clock by an integer. That integer is split into a high-time count and a low-time count, so the duty cycle is set directly. An optional half-step bit moves the falling edge of the output half a fast-clock period later, which gives duty resolution of one half input period. For that bit to work, the low count must be at least 1.

Stages are laid out as a chain. A stage takes its clock either from the fast clock or from the raw counter output of the stage before it. A chained stage therefore divides by the product of its own setting and the settings of the stages ahead of it. The chain configuration is fixed while reset is held. A bypass bit makes a stage pass its input clock straight through. New high and low settings are taken up only when a period begins, so a change never produces a short pulse.

Top module: `pdiv_chain`

## Requirements
- R1: While `rst_n` is low, `casc_out` and every non-bypassed `clk_out` bit are low. After release, a stage output stays low and first rises on the (low+1)-th rising edge of its stage clock.
- R2: With the half-step bit clear, a stage output is high for `high` and low for `low` stage-clock cycles. The period is therefore high+low cycles.
- R3: With the half-step bit set, the high time is 2·high+1 half periods of the stage clock and the low time is 2·low−1 half periods. The period is unchanged.
- R4: With the bypass bit set, `clk_out` of that stage equals its stage clock, and its high and low counts have no effect on it.
- R5: High count, low count and half-step are captured only at the start of a period, which is the start of a low phase. A change made during a high phase first shows in the following low phase. A change made during a low phase first shows one full period later.
- R6: A stage whose chain-select bit is 1 is clocked by the previous stage's raw output, which ignores that stage's half-step and bypass bits. Its ratio to the fast clock is the product of the stage settings. The select bit of stage 0 has no effect.
- R7: The chain-select bits are sampled only while `rst_n` is low. Changes after release have no effect until the next reset.
- R8: Each count is `CW` bits wide (8 by default). Code 0 means 2^CW (256), so one stage divides by at most 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_hi | input | STAGES*CW | High-time count per stage, stage i at bits [i*CW +: CW] |
| cnt_lo | input | STAGES*CW | Low-time count per stage, same packing |
| half_adj | input | STAGES | Half-step duty adjust per stage |
| bypass | input | STAGES | Pass the stage clock straight to the output |
| casc_sel | input | STAGES | 1 = clock stage i from stage i-1 raw output |
| clk_out | output | STAGES | Divided clock of each stage |
| casc_out | output | 1 | Raw counter output of the last stage |

## Verification
On every cycle, the assertions check three things. The counter's phase flips only when its remaining count is zero. The captured high count and half-step hold still except at a period start. The latched chain configuration never moves outside reset, and the raw output stays low during reset. Directed scenarios are needed for everything measured in time. These are the high and low widths in half periods, the half-step shift, bypass pass-through, the first-edge delay after reset, the period boundary at which a new setting takes effect, and the product ratio of a two-stage chain.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_t;

  // Length in stage-clock cycles encoded by a count code; zero means 2^cw.
  function automatic int unsigned count_len(logic [15:0] code, int unsigned cw);
    int unsigned m;
    m = 32'd1 << cw;
    return (code & 16'(m - 1)) == 16'd0 ? m : int'(code);
  endfunction

  // High width in half periods of the stage clock.
  function automatic int unsigned high_halves(int unsigned len, logic adj);
    return 2 * len + (adj ? 1 : 0);
  endfunction

  // Low width in half periods of the stage clock.
  function automatic int unsigned low_halves(int unsigned len, logic adj);
    return 2 * len - (adj ? 1 : 0);
  endfunction

endpackage

// File: rtl/pdiv_phase_cnt.sv
module pdiv_phase_cnt
  import pdiv_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic [CW-1:0] hi_code,
  input  logic [CW-1:0] lo_code,
  input  logic          hadj_in,
  output logic          q_o,
  output logic          hadj_o
);

  logic          arm;
  phase_t        phase;
  logic [CW-1:0] rem;
  logic [CW-1:0] hi_sh;
  logic          hadj_sh;

  // Named events for the assertions.
  logic rem_zero, end_high, end_low, load_now;
  int unsigned lo_len, hi_len;

  assign rem_zero = (rem == '0);
  assign end_high = (phase == PH_HIGH) && rem_zero;
  assign end_low  = (phase == PH_LOW) && rem_zero && !arm;
  assign load_now = arm || end_high;
  assign lo_len   = count_len(16'(lo_code), CW);
  assign hi_len   = count_len(16'(hi_sh), CW);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      arm     <= 1'b1;
      phase   <= PH_LOW;
      rem     <= '0;
      hi_sh   <= '0;
      hadj_sh <= 1'b0;
    end else if (load_now) begin
      arm     <= 1'b0;
      phase   <= PH_LOW;
      rem     <= CW'(lo_len - 1);
      hi_sh   <= hi_code;
      hadj_sh <= hadj_in;
    end else if (end_low) begin
      phase   <= PH_HIGH;
      rem     <= CW'(hi_len - 1);
    end else begin
      rem     <= rem - 1'b1;
    end
  end

  assign q_o    = (phase == PH_HIGH);
  assign hadj_o = hadj_sh;

  // R2
  phase_at_zero_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (phase != $past(phase)) |-> $past(rem_zero));

  // R5
  shadow_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !$past(load_now) |-> ($stable(hi_sh) && $stable(hadj_sh)));

endmodule

// File: rtl/pdiv_halfstep.sv
module pdiv_halfstep (
  input  logic sclk,
  input  logic rst_n,
  input  logic q_i,
  input  logic hadj_i,
  input  logic bypass_i,
  output logic out_o
);

  logic q_n, hadj_n, stretched;

  // Falling-edge copies: the tail after a period ends follows the old setting.
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      q_n    <= 1'b0;
      hadj_n <= 1'b0;
    end else begin
      q_n    <= q_i;
      hadj_n <= hadj_i;
    end
  end

  assign stretched = q_i | (q_n & hadj_n);
  assign out_o     = bypass_i ? sclk : stretched;

  // R3
  half_tail_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    (q_n && hadj_n) |-> $past(q_i));

endmodule

// File: rtl/pdiv_stage.sv
module pdiv_stage #(
  parameter int CW = 8
) (
  input  logic          fast_clk,
  input  logic          rst_n,
  input  logic          prev_i,
  input  logic          casc_sel_i,
  input  logic [CW-1:0] hi_code,
  input  logic [CW-1:0] lo_code,
  input  logic          hadj_i,
  input  logic          bypass_i,
  output logic          out_o,
  output logic          raw_o
);

  logic casc_q;
  logic sclk;
  logic q, hadj_sh;

  // Chain selection is captured only while reset is held.
  always_ff @(posedge fast_clk) begin
    if (!rst_n) casc_q <= casc_sel_i;
  end

  assign sclk = casc_q ? prev_i : fast_clk;

  pdiv_phase_cnt #(.CW(CW)) cnt_i (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .hi_code (hi_code),
    .lo_code (lo_code),
    .hadj_in (hadj_i),
    .q_o     (q),
    .hadj_o  (hadj_sh)
  );

  pdiv_halfstep hs_i (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .q_i      (q),
    .hadj_i   (hadj_sh),
    .bypass_i (bypass_i),
    .out_o    (out_o)
  );

  assign raw_o = q;

  // R7
  casc_frozen_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    $stable(casc_q));

endmodule

// File: rtl/pdiv_chain.sv
module pdiv_chain #(
  parameter int STAGES = 2,
  parameter int CW     = 8
) (
  input  logic                 fast_clk,
  input  logic                 rst_n,
  input  logic [STAGES*CW-1:0] cnt_hi,
  input  logic [STAGES*CW-1:0] cnt_lo,
  input  logic [STAGES-1:0]    half_adj,
  input  logic [STAGES-1:0]    bypass,
  input  logic [STAGES-1:0]    casc_sel,
  output logic [STAGES-1:0]    clk_out,
  output logic                 casc_out
);

  localparam int LINKS = STAGES + 1;

  logic [LINKS-1:0] link;

  // Stage 0 has no predecessor: its chain input is the fast clock itself.
  assign link[0] = fast_clk;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    pdiv_stage #(.CW(CW)) stg_i (
      .fast_clk   (fast_clk),
      .rst_n      (rst_n),
      .prev_i     (link[s]),
      .casc_sel_i (casc_sel[s]),
      .hi_code    (cnt_hi[s*CW +: CW]),
      .lo_code    (cnt_lo[s*CW +: CW]),
      .hadj_i     (half_adj[s]),
      .bypass_i   (bypass[s]),
      .out_o      (clk_out[s]),
      .raw_o      (link[s+1])
    );
  end

  assign casc_out = link[LINKS-1];

  // R1
  rst_quiet_chk: assert property (@(posedge fast_clk)
    !rst_n |-> !casc_out);

endmodule

// File: tb/pdiv_chain_tb_top.sv
module pdiv_chain_tb_top;
  localparam int ST = 2;
  localparam int CW = 8;

  logic             fast_clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [ST*CW-1:0] cnt_hi = '0;
  logic [ST*CW-1:0] cnt_lo = '0;
  logic [ST-1:0]    half_adj = '0;
  logic [ST-1:0]    bypass = '0;
  logic [ST-1:0]    casc_sel = '0;
  logic [ST-1:0]    clk_out;
  logic             casc_out;

  int n_run = 0;
  int n_fail = 0;

  pdiv_chain #(.STAGES(ST), .CW(CW)) dut_i (
    .fast_clk(fast_clk), .rst_n(rst_n), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
    .half_adj(half_adj), .bypass(bypass), .casc_sel(casc_sel),
    .clk_out(clk_out), .casc_out(casc_out)
  );

  always #10 fast_clk = ~fast_clk;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Bench's own expectations, in half periods of the fast clock.
  function automatic int len_of(int code);
    return (code == 0) ? 256 : code;
  endfunction

  task automatic set_stage(int s, int hi, int lo, logic ha, logic by);
    cnt_hi[s*CW +: CW] = CW'(hi);
    cnt_lo[s*CW +: CW] = CW'(lo);
    half_adj[s] = ha;
    bypass[s]   = by;
  endtask

  task automatic do_reset(logic [ST-1:0] chain);
    rst_n = 1'b0;
    casc_sel = chain;
    #40;
    rst_n = 1'b1;
  endtask

  // Samples every 10 ns at 5 ns after each clock edge.
  task automatic measure(int s, output int h, output int l);
    int g = 0;
    while (clk_out[s] !== 1'b0 && g < 4000) begin #10; g++; end
    while (clk_out[s] !== 1'b1 && g < 4000) begin #10; g++; end
    h = 0;
    while (clk_out[s] === 1'b1 && h < 4000) begin h++; #10; end
    l = 0;
    while (clk_out[s] === 1'b0 && l < 4000) begin l++; #10; end
  endtask

  task automatic t_reset();
    int n = 0;
    set_stage(0, 3, 5, 1'b0, 1'b0);
    set_stage(1, 2, 2, 1'b0, 1'b0);
    rst_n = 1'b0;
    casc_sel = '0;
    #40;
    chk("R1 clk_out low in reset", int'(clk_out[0]), 0);
    chk("R1 casc_out low in reset", int'(casc_out), 0);
    rst_n = 1'b1;
    while (clk_out[0] === 1'b0 && n < 100) begin n++; #10; end
    chk("R1 first rise after low+1 edges", n, 2 * 5 + 1);
  endtask

  task automatic t_basic();
    int h, l;
    measure(0, h, l);
    chk("R2 high 3", h, 6);
    chk("R2 low 5", l, 10);
    set_stage(0, 1, 1, 1'b0, 1'b0);
    measure(0, h, l); measure(0, h, l);
    chk("R2 high 1", h, 2);
    chk("R2 low 1", l, 2);
    set_stage(0, 7, 2, 1'b0, 1'b0);
    measure(0, h, l); measure(0, h, l);
    chk("R2 high 7", h, 14);
    chk("R2 low 2", l, 4);
  endtask

  task automatic t_half();
    int h, l;
    set_stage(0, 2, 3, 1'b1, 1'b0);
    measure(0, h, l); measure(0, h, l);
    chk("R3 high 2+half", h, 2 * 2 + 1);
    chk("R3 low 3-half", l, 2 * 3 - 1);
    set_stage(0, 1, 1, 1'b1, 1'b0);
    measure(0, h, l); measure(0, h, l);
    chk("R3 high 1+half", h, 3);
    chk("R3 low 1-half", l, 1);
  endtask

  task automatic t_zero();
    int h, l;
    set_stage(0, 0, 1, 1'b0, 1'b0);
    measure(0, h, l); measure(0, h, l);
    chk("R8 high code 0 is 256", h, 2 * len_of(0));
    chk("R8 low code 1", l, 2);
    set_stage(0, 2, 0, 1'b0, 1'b0);
    measure(0, h, l); measure(0, h, l);
    chk("R8 low code 0 is 256", l, 2 * len_of(0));
  endtask

  task automatic t_bypass();
    int h, l;
    set_stage(0, 9, 4, 1'b1, 1'b1);
    measure(0, h, l);
    chk("R4 bypass high", h, 1);
    chk("R4 bypass low", l, 1);
    set_stage(0, 2, 2, 1'b0, 1'b0);
    measure(0, h, l); measure(0, h, l);
    chk("R4 divide resumes after bypass", h, 4);
  endtask

  task automatic t_boundary();
    int h = 0, l = 0, g = 0;
    set_stage(0, 4, 4, 1'b0, 1'b0);
    measure(0, h, l); measure(0, h, l);
    while (clk_out[0] === 1'b1 && g < 100) begin #10; g++; end
    while (clk_out[0] === 1'b0 && g < 200) begin #10; g++; end
    set_stage(0, 1, 6, 1'b0, 1'b0);
    h = 0;
    while (clk_out[0] === 1'b1 && h < 100) begin h++; #10; end
    chk("R5 current high keeps old count", h, 8);
    l = 0;
    while (clk_out[0] === 1'b0 && l < 100) begin l++; #10; end
    chk("R5 next low uses new count", l, 12);
    h = 0;
    while (clk_out[0] === 1'b1 && h < 100) begin h++; #10; end
    chk("R5 next high uses new count", h, 2);
    // Change during a low phase: the running period keeps the old high count.
    set_stage(0, 3, 6, 1'b0, 1'b0);
    l = 0;
    while (clk_out[0] === 1'b0 && l < 100) begin l++; #10; end
    h = 0;
    while (clk_out[0] === 1'b1 && h < 100) begin h++; #10; end
    chk("R5 change in low waits a period", h, 2);
  endtask

  task automatic t_chain();
    int h, l;
    set_stage(0, 2, 2, 1'b0, 1'b0);
    set_stage(1, 1, 1, 1'b0, 1'b0);
    do_reset(2'b11);
    measure(1, h, l); measure(1, h, l);
    chk("R6 chain 4x2 high", h, 8);
    chk("R6 chain 4x2 low", l, 8);
    set_stage(1, 3, 1, 1'b0, 1'b0);
    measure(1, h, l); measure(1, h, l);
    chk("R6 chain 4x4 high", h, 24);
    chk("R6 chain 4x4 low", l, 8);
    set_stage(0, 2, 2, 1'b1, 1'b0);
    measure(1, h, l); measure(1, h, l);
    chk("R6 chain ignores stage0 half-step", h, 24);
  endtask

  task automatic t_static();
    int h, l;
    set_stage(0, 2, 2, 1'b0, 1'b0);
    set_stage(1, 1, 1, 1'b0, 1'b0);
    casc_sel = 2'b00;
    measure(1, h, l); measure(1, h, l);
    chk("R7 chain kept after select cleared", h, 8);
    chk("R7 chain kept low width", l, 8);
  endtask

  initial begin
    #5;
    t_reset();
    t_basic();
    t_half();
    t_zero();
    t_bypass();
    t_boundary();
    t_chain();
    t_static();
    summary();
  end

  initial begin
    #(20 * 190000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

endmodule